// File: doc/BRIEF.md
# Software-Refilled Fully Associative Address Translation Buffer

This block translates 32-bit virtual addresses into physical addresses through a small fully associative table of cached page table entries. Each cycle it may receive a lookup: a virtual address and a read/write flag. When a stored entry carries the same 20-bit virtual page number, the physical address comes out combinationally in that cycle. No table walk is needed.

When no entry matches, the block raises a miss exception. It also records, in a context register, the memory address of the page table entry that system software has to fetch. That address is the page table base plus the page number scaled by four. Software loads the fetched entry into a staging register and then issues a random-write command. The command copies the staged entry into the slot that a free-running counter points at in that cycle.

A matching entry whose valid bit is clear is reported as a page fault. A write that hits sets the entry's dirty bit. Only supervisor-mode software may change the page table base, the staging register or the table itself. A flush input empties the table in a single cycle.

Top module: `tlb_xlate`

## Requirements
- R1: When `lk_vld` is high and an occupied slot holds `lk_vaddr[31:12]` with its valid bit set, `lk_hit` is 1 and `lk_paddr` equals {stored frame number, `lk_vaddr[11:0]`} in the same cycle. `lk_paddr` is 0 whenever `lk_hit` is 0.
- R2: When `lk_vld` is high and no occupied slot holds the page number, `miss_exc` is 1 and both `lk_hit` and `pfault` are 0.
- R3: At the clock edge that ends a cycle with `miss_exc` high, `ctx_addr` becomes page-table base + (page number << 2), modulo 2^32. In every other cycle `ctx_addr` holds its value.
- R4: When `lk_vld` is high and an occupied slot matches but its valid bit is 0, `pfault` is 1 and both `lk_hit` and `miss_exc` are 0.
- R5: A 4-bit slot counter is 0 during reset and advances by one, wrapping, at every clock edge. A supervisor `wr_rand` copies the staging register, as it stood before that edge, into the slot the counter names. The staging register layout is [41:22] page number, [21:2] frame number, [1] dirty, [0] valid.
- R6: A lookup with `lk_write` high that sets `lk_hit` also sets the dirty bit of the matched slot at that edge. `lk_dirty` shows the matched slot's dirty bit, and is 0 when nothing matches.
- R7: `base_we`, `stage_we` and `wr_rand` have no effect while `priv_super` is 0.
- R8: `flush` empties every slot at one edge, and it overrides a `wr_rand` issued in the same cycle.
- R9: When several occupied slots hold the same page number, the lowest-numbered slot supplies the result.
- R10: After reset every slot is empty, and the base, staging and context registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vld | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | Lookup is a store |
| priv_super | input | 1 | Supervisor mode |
| flush | input | 1 | Empty all slots |
| base_we | input | 1 | Write page table base |
| base_wdata | input | 32 | New page table base |
| stage_we | input | 1 | Write staging entry register |
| stage_wdata | input | 42 | New staged entry |
| wr_rand | input | 1 | Copy staged entry into the counter-selected slot |
| lk_hit | output | 1 | Translation succeeded |
| lk_paddr | output | 32 | Physical address |
| lk_dirty | output | 1 | Dirty bit of the matched slot |
| miss_exc | output | 1 | No slot matches: miss exception |
| pfault | output | 1 | Slot matches but the page is not resident |
| ctx_addr | output | 32 | Address of the page table entry for the last miss |

## Verification
A corrupt slot, or a wrong presence bit, shows at the ports the first time that page number is looked up. It appears as a wrong frame number, or as a miss in place of a hit, or the reverse. A wrong counter value or a wrong staging register stays hidden until a refill is followed by a lookup, so every refill is soon followed by a lookup. A wrong context register is visible on the edge right after a miss. The bench models the whole table behaviourally and compares every output on every cycle, so a divergence is reported within one cycle of the lookup that exposes it.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned VA_W      = 32;
  localparam int unsigned OFF_W     = 12;
  localparam int unsigned VPN_W     = VA_W - OFF_W;
  localparam int unsigned PFN_W     = 20;
  localparam int unsigned PTE_SHIFT = 2;

  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic [PFN_W-1:0] pfn;
    logic             dirty;
    logic             valid;
  } pte_t;

  localparam int unsigned ENTRY_W = $bits(pte_t);

  // address of the page table entry for a page number
  function automatic logic [VA_W-1:0] pte_addr(input logic [VA_W-1:0] base,
                                               input logic [VPN_W-1:0] vpn);
    return base + ({{(VA_W-VPN_W){1'b0}}, vpn} << PTE_SHIFT);
  endfunction
endpackage

// File: rtl/tlb_slot_rng.sv
module tlb_slot_rng #(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [IDX_W-1:0] slot
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot <= '0;
    else        slot <= slot + 1'b1;
  end

  // R5
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> slot == $past(slot) + 1'b1);
endmodule

// File: rtl/tlb_ctl_regs.sv
module tlb_ctl_regs
  import tlb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             priv_super,
  input  logic             base_we,
  input  logic [VA_W-1:0]  base_wdata,
  input  logic             stage_we,
  input  pte_t             stage_wdata,
  input  logic             miss_evt,
  input  logic [VPN_W-1:0] miss_vpn,
  output pte_t             stage_q,
  output logic [VA_W-1:0]  ctx_q
);
  logic [VA_W-1:0] base_q;
  logic            base_upd, stage_upd;

  assign base_upd  = base_we  & priv_super;
  assign stage_upd = stage_we & priv_super;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      stage_q <= '0;
      ctx_q   <= '0;
    end else begin
      if (base_upd)  base_q  <= base_wdata;
      if (stage_upd) stage_q <= stage_wdata;
      if (miss_evt)  ctx_q   <= pte_addr(base_q, miss_vpn);
    end
  end

  // R3
  ctx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_evt |=> $stable(ctx_q));
  // R7
  stage_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !priv_super |=> $stable(stage_q));
  // R7
  base_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !priv_super |=> $stable(base_q));
endmodule

// File: rtl/tlb_array.sv
module tlb_array
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  pte_t             fill_pte,
  input  logic             mark_en,
  input  logic [VPN_W-1:0] look_vpn,
  output logic             any_match,
  output logic [IDX_W-1:0] match_idx,
  output logic [PFN_W-1:0] match_pfn,
  output logic             match_valid,
  output logic             match_dirty
);
  logic [ENTRIES-1:0] match_vec;
  logic [ENTRIES-1:0] pres_vec;
  pte_t               ent_arr [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic pres;
    pte_t ent;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pres <= 1'b0;
        ent  <= '0;
      end else if (flush) begin
        pres <= 1'b0;
      end else if (fill_en && fill_idx == IDX_W'(g)) begin
        pres <= 1'b1;
        ent  <= fill_pte;
      end else if (mark_en && match_idx == IDX_W'(g)) begin
        ent.dirty <= 1'b1;
      end
    end
    assign pres_vec[g]  = pres;
    assign ent_arr[g]   = ent;
    assign match_vec[g] = pres && (ent.vpn == look_vpn);
  end

  // lowest index wins
  always_comb begin
    match_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match_vec[i]) match_idx = IDX_W'(i);
  end

  assign any_match   = |match_vec;
  assign match_pfn   = ent_arr[match_idx].pfn;
  assign match_valid = ent_arr[match_idx].valid;
  assign match_dirty = ent_arr[match_idx].dirty;

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> pres_vec == '0);
  // R9
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_match |-> match_vec[match_idx] &&
      ((match_vec & ((ENTRIES'(1) << match_idx) - 1'b1)) == '0));
  // R6
  dirty_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_en && !flush && !(fill_en && fill_idx == match_idx))
      |=> ent_arr[$past(match_idx)].dirty);
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lk_vld,
  input  logic [VA_W-1:0]     lk_vaddr,
  input  logic                lk_write,
  input  logic                priv_super,
  input  logic                flush,
  input  logic                base_we,
  input  logic [VA_W-1:0]     base_wdata,
  input  logic                stage_we,
  input  logic [ENTRY_W-1:0]  stage_wdata,
  input  logic                wr_rand,
  output logic                lk_hit,
  output logic [VA_W-1:0]     lk_paddr,
  output logic                lk_dirty,
  output logic                miss_exc,
  output logic                pfault,
  output logic [VA_W-1:0]     ctx_addr
);
  logic [VPN_W-1:0] look_vpn;
  logic [IDX_W-1:0] rnd_slot, match_idx;
  logic [PFN_W-1:0] match_pfn;
  logic             any_match, match_valid, match_dirty;
  logic             fill_en, mark_en;
  pte_t             stage_q;

  assign look_vpn = lk_vaddr[VA_W-1:OFF_W];
  assign fill_en  = wr_rand & priv_super;
  assign mark_en  = lk_hit & lk_write;

  tlb_slot_rng #(.IDX_W(IDX_W)) u_rng (
    .clk(clk), .rst_n(rst_n), .slot(rnd_slot));

  tlb_ctl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .priv_super(priv_super),
    .base_we(base_we), .base_wdata(base_wdata),
    .stage_we(stage_we), .stage_wdata(pte_t'(stage_wdata)),
    .miss_evt(miss_exc), .miss_vpn(look_vpn),
    .stage_q(stage_q), .ctx_q(ctx_addr));

  tlb_array #(.ENTRIES(ENTRIES)) u_arr (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .fill_en(fill_en), .fill_idx(rnd_slot), .fill_pte(stage_q),
    .mark_en(mark_en), .look_vpn(look_vpn),
    .any_match(any_match), .match_idx(match_idx),
    .match_pfn(match_pfn), .match_valid(match_valid),
    .match_dirty(match_dirty));

  assign lk_hit   = lk_vld & any_match & match_valid;
  assign pfault   = lk_vld & any_match & ~match_valid;
  assign miss_exc = lk_vld & ~any_match;
  assign lk_dirty = lk_vld & any_match & match_dirty;
  assign lk_paddr = lk_hit ? {match_pfn, lk_vaddr[OFF_W-1:0]} : '0;

  // R1 R2 R4
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lk_hit, miss_exc, pfault}));
  // R1
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_vld |-> !lk_hit && !miss_exc && !pfault);
endmodule

// File: tb/sim_tlb_xlate.sv
`timescale 1ns/1ps
module sim_tlb_xlate;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        lk_vld = 0, lk_write = 0, priv_super = 0, flush = 0;
  logic        base_we = 0, stage_we = 0, wr_rand = 0;
  logic [31:0] lk_vaddr = '0, base_wdata = '0;
  logic [41:0] stage_wdata = '0;
  logic        lk_hit, lk_dirty, miss_exc, pfault;
  logic [31:0] lk_paddr, ctx_addr;

  always #2.5 clk = ~clk;

  tlb_xlate u0 (.*);

  int checks = 0, failures = 0;
  bit done = 0;

  // behavioural model
  bit        m_pres [16];
  bit [19:0] m_vpn  [16];
  bit [19:0] m_pfn  [16];
  bit        m_v    [16];
  bit        m_d    [16];
  bit [31:0] m_base = 0, m_ctx = 0;
  bit [41:0] m_stage = 0;
  int        m_cnt = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit vld, bit [31:0] va, bit wr, bit sup, bit fl,
                      bit bw, bit [31:0] bd, bit sw, bit [41:0] sd,
                      bit wrr, string tag);
    int idx;
    bit e_hit, e_miss, e_pf, e_d;
    bit [31:0] e_pa;
    lk_vld = vld; lk_vaddr = va; lk_write = wr; priv_super = sup;
    flush = fl; base_we = bw; base_wdata = bd; stage_we = sw;
    stage_wdata = sd; wr_rand = wrr;
    #1;
    idx = -1;
    for (int i = 0; i < 16; i++)
      if (idx < 0 && m_pres[i] && m_vpn[i] == va[31:12]) idx = i;
    e_miss = vld && idx < 0;
    e_hit = 0; e_pf = 0; e_d = 0;
    if (vld && idx >= 0) begin
      e_hit = m_v[idx]; e_pf = !m_v[idx]; e_d = m_d[idx];
    end
    e_pa = e_hit ? {m_pfn[idx], va[11:0]} : 32'h0;
    chk({tag, " R1 hit"}, lk_hit, e_hit);
    chk({tag, " R1 paddr"}, lk_paddr, e_pa);
    chk({tag, " R2 miss"}, miss_exc, e_miss);
    chk({tag, " R4 fault"}, pfault, e_pf);
    chk({tag, " R6 dirty"}, lk_dirty, e_d);
    chk({tag, " R3 ctx"}, ctx_addr, m_ctx);
    @(posedge clk);
    if (e_miss) m_ctx = m_base + {va[31:12], 2'b00};
    if (e_hit && wr) m_d[idx] = 1;
    if (fl) begin
      for (int i = 0; i < 16; i++) m_pres[i] = 0;
    end else if (sup && wrr) begin
      m_pres[m_cnt] = 1; m_vpn[m_cnt] = m_stage[41:22];
      m_pfn[m_cnt] = m_stage[21:2]; m_d[m_cnt] = m_stage[1];
      m_v[m_cnt] = m_stage[0];
    end
    if (sup && bw) m_base = bd;
    if (sup && sw) m_stage = sd;
    m_cnt = (m_cnt + 1) % 16;
    @(negedge clk);
  endtask

  task automatic look(bit [31:0] va, bit wr, string tag);
    step(1, va, wr, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "idle");
  endtask
  task automatic load_and_fill(bit sup, bit [19:0] vpn, bit [19:0] pfn,
                               bit d, bit v, string tag);
    step(0, 0, 0, sup, 0, 0, 0, 1, {vpn, pfn, d, v}, 0, tag);
    step(0, 0, 0, sup, 0, 0, 0, 0, 0, 1, tag);
  endtask

  initial begin
    bit [31:0] lf;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10: empty after reset, ctx zero
    look(32'h1234_5678, 0, "R10");
    chk("R10 ctx after first miss", ctx_addr, 32'h0004_8D14);
    // R3 with new base
    step(0, 0, 0, 1, 0, 1, 32'h8000_0000, 0, 0, 0, "R3 base");
    look(32'h0000_3ABC, 0, "R3");
    chk("R3 ctx value", ctx_addr, 32'h8000_000C);
    // R1 refill then hit
    load_and_fill(1, 20'h12345, 20'hABCDE, 0, 1, "R5");
    look(32'h1234_5678, 0, "R1");
    // R7 user mode writes ignored
    load_and_fill(0, 20'h00001, 20'h0BEEF, 0, 1, "R7");
    step(0, 0, 0, 0, 0, 1, 32'h4000_0000, 0, 0, 0, "R7 base");
    look(32'h0000_1000, 0, "R7");
    chk("R7 ctx uses old base", ctx_addr, 32'h8000_0004);
    // R6 dirty on write hit
    look(32'h1234_5000, 1, "R6");
    look(32'h1234_5FFF, 0, "R6");
    chk("R6 dirty set", lk_dirty, 1'b1);
    // R4 page fault
    load_and_fill(1, 20'h00777, 20'h00123, 0, 0, "R4");
    look(32'h0077_7000, 1, "R4");
    // R9 duplicate page numbers
    load_and_fill(1, 20'h22222, 20'h11111, 0, 1, "R9");
    repeat (5) idle();
    load_and_fill(1, 20'h22222, 20'h33333, 0, 1, "R9");
    look(32'h2222_2010, 0, "R9");
    // R5 fill all slots, refill each cycle
    for (int i = 0; i < 20; i++)
      step(0, 0, 0, 1, 0, 0, 0, 1, {20'h00100 + 20'(i), 20'h50000 + 20'(i),
           1'b0, 1'b1}, 1, "R5 sweep");
    for (int i = 0; i < 20; i++) look({20'h00100 + 20'(i), 12'h044}, 0, "R5");
    // R8 flush overrides refill
    step(0, 0, 0, 1, 1, 0, 0, 0, 0, 1, "R8");
    look(32'h0010_0044, 0, "R8");
    chk("R8 miss after flush", miss_exc, 1'b1);
    // mixed pattern
    lf = 32'hACE1_0001;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      step(lf[0], {16'h0, lf[7:4], lf[19:8]}, lf[1], lf[2] | lf[3],
           lf[27] & lf[28] & lf[29], lf[9] & lf[10], {lf[15:0], 16'h0},
           lf[11], {16'h0, lf[7:4], lf[20:12], lf[31:16], lf[5], lf[6]},
           lf[12] & lf[13], "mix");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule